// File: doc/BRIEF.md
# SPI status and interrupt controller

This block keeps the event and level flags of an SPI peripheral, holds the per-source interrupt enables and produces one interrupt request line. A separate shift engine supplies event inputs: a received word is ready to move into the receive holding register, the fill state of both holding registers, a request to shift out a transmit word, the slave-mode indication and the raw active-low slave-select lines. The block returns a stall signal. The stall holds off a new master-mode transfer that would otherwise overwrite unread receive data.

Software reaches three word addresses over a simple register bus. These are a status register, an enable-set alias and an enable-clear alias. The enables are never written directly: each alias changes only the bits written as one. The event flags latch until software writes one to them in the status register. The interrupt is a registered level: the OR, over all sources, of each flag masked by its enable.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Source bit positions are shared by status and enables: 0 receive ready, 1 transmit ready, 2 receive overrun, 3 transmit underrun, 4 select asserted, 5 select released. Writing address 1 sets each enable bit written as one and leaves the bits written as zero unchanged. Reading address 1 or address 2 returns the enable set.
- R2: Writing address 2 clears each enable bit written as one and leaves the other enable bits unchanged.
- R3: After reset, all enables, all event flags and `irq_o` are zero.
- R4: Status bit 0 equals `rx_full_i` and status bit 1 equals `tx_empty_i` in the same cycle. Writes do not change either bit.
- R5: In slave mode (`slave_mode_i`=1), a cycle with `rx_done_i`=1 and `rx_full_i`=1 sets status bit 2 at the next clock edge.
- R6: In master mode, status bit 2 is never set. `stall_o` is 1 exactly when `slave_mode_i`=0 and `rx_full_i`=1.
- R7: In slave mode, a cycle with `tx_shift_req_i`=1 and `tx_empty_i`=1 sets status bit 3 at the next edge. In master mode this does nothing.
- R8: Status bit 4 is set one edge after any select line goes from high (deasserted) to low (asserted).
- R9: Status bit 5 is set one edge after the last asserted select line returns high, leaving none asserted.
- R10: Status bits 2 to 5 stay set until software writes one to them at address 0. When a set event and such a clear fall in the same cycle, the bit ends up set.
- R11: `irq_o` at each edge takes the OR over all bits of status AND enable, as sampled before that edge.
- R12: Reads return zero in bits 31:6 and at address 3. Writes to bits 31:6 have no effect. `rdata_o` is zero when `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read enable |
| addr_i | input | 2 | Word address: 0 status, 1 enable set, 2 enable clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| rx_done_i | input | 1 | A received word must move into the receive holding register |
| rx_full_i | input | 1 | Receive holding register holds unread data |
| tx_empty_i | input | 1 | Transmit holding register can accept data |
| tx_shift_req_i | input | 1 | The engine needs a transmit word to shift out |
| slave_mode_i | input | 1 | 1 for slave mode, 0 for master mode |
| ssel_ni | input | 4 | Raw slave-select lines, active low |
| stall_o | output | 1 | Hold off a new master transfer |
| irq_o | output | 1 | Interrupt request, registered level |

## Verification
A hardware event and a software write-one-to-clear of the same status bit can meet in one cycle. The bench provokes this by changing the select lines in the same cycle as a clear write to the status register. The bit must read back as set. The interrupt register can also update at the same edge as an enable write. The bench sweeps every flag pattern against every enable mask and checks `irq_o` one edge after the enable write. Before that edge, it checks that the request has not yet followed the new mask.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC   = 6;
  localparam int IDX_RXRDY = 0;
  localparam int IDX_TXRDY = 1;
  localparam int IDX_RXOVR = 2;
  localparam int IDX_TXUDR = 3;
  localparam int IDX_SSA   = 4;
  localparam int IDX_SSD   = 5;
  localparam int NUM_EVT   = NUM_SRC - IDX_RXOVR;
  localparam int REG_STAT  = 0;
  localparam int REG_ENSET = 1;
  localparam int REG_ENCLR = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/spi_ss_edge.sv
module spi_ss_edge #(
  parameter int SS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SS_W-1:0] ssel_ni,
  output logic            ss_asrt_o,
  output logic            ss_dsrt_o
);
  logic [SS_W-1:0] act_q;
  logic [SS_W-1:0] act_d;

  assign act_d = ~ssel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  // any line newly asserted
  assign ss_asrt_o = |(act_d & ~act_q);
  // last asserted line released
  assign ss_dsrt_o = (|act_q) & ~(|act_d);

  assert_ss_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_dsrt_o |-> !ss_asrt_o);
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t set_i,
  input  evt_vec_t clr_i,
  output evt_vec_t flags_o
);
  evt_vec_t flags_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[k] <= 1'b0;
      else if (set_i[k]) flags_q[k] <= 1'b1;  // set beats clear
      else if (clr_i[k]) flags_q[k] <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flags_q[k]);
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[k] && !clr_i[k]) |=> flags_q[k]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/spi_irq_en.sv
module spi_irq_en
  import spi_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_we_i,
  input  logic     clr_we_i,
  input  src_vec_t wmask_i,
  output src_vec_t en_o
);
  src_vec_t en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (set_we_i) en_q <= en_q | wmask_i;
    else if (clr_we_i) en_q <= en_q & ~wmask_i;
  end

  assign en_o = en_q;

  assert_en_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((en_q & $past(wmask_i)) == '0));
  assert_en_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((en_q & $past(wmask_i)) == $past(wmask_i)));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int SS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_done_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic              tx_shift_req_i,
  input  logic              slave_mode_i,
  input  logic [SS_W-1:0]   ssel_ni,
  output logic              stall_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic     wr_stat, wr_set, wr_clr;
  src_vec_t wmask;
  src_vec_t en;
  src_vec_t status;
  evt_vec_t evt_set, evt_clr, evt_flags;
  logic     ss_asrt, ss_dsrt;
  logic     irq_q;

  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(REG_STAT));
  assign wr_set  = wr_en_i && (addr_i == ADDR_W'(REG_ENSET));
  assign wr_clr  = wr_en_i && (addr_i == ADDR_W'(REG_ENCLR));
  assign wmask   = wdata_i[NUM_SRC-1:0];

  spi_ss_edge #(.SS_W(SS_W)) u_ss_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ssel_ni   (ssel_ni),
    .ss_asrt_o (ss_asrt),
    .ss_dsrt_o (ss_dsrt)
  );

  // event sources, indexed from IDX_RXOVR
  assign evt_set[IDX_RXOVR-IDX_RXOVR] = slave_mode_i & rx_done_i & rx_full_i;
  assign evt_set[IDX_TXUDR-IDX_RXOVR] = slave_mode_i & tx_shift_req_i & tx_empty_i;
  assign evt_set[IDX_SSA-IDX_RXOVR]   = ss_asrt;
  assign evt_set[IDX_SSD-IDX_RXOVR]   = ss_dsrt;
  assign evt_clr = wr_stat ? wmask[NUM_SRC-1:IDX_RXOVR] : '0;

  spi_evt_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .clr_i   (evt_clr),
    .flags_o (evt_flags)
  );

  spi_irq_en u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr_set),
    .clr_we_i (wr_clr),
    .wmask_i  (wmask),
    .en_o     (en)
  );

  assign status = {evt_flags, tx_empty_i, rx_full_i};

  // master mode: refuse to start while unread receive data would be overwritten
  assign stall_o = ~slave_mode_i & rx_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & en);
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        ADDR_W'(REG_STAT):  rdata_o = {{PAD_W{1'b0}}, status};
        ADDR_W'(REG_ENSET),
        ADDR_W'(REG_ENCLR): rdata_o = {{PAD_W{1'b0}}, en};
        default:            rdata_o = '0;
      endcase
    end
  end

  assert_no_ovr_master_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[IDX_RXOVR]) |-> $past(slave_mode_i));
  assert_no_udr_master_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[IDX_TXUDR]) |-> $past(slave_mode_i));
  assert_ss_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_asrt |=> status[IDX_SSA]);
  assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(|en) |-> !irq_o);
endmodule

// File: tb/test_spi_irq_ctrl.sv
module test_spi_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_done = 1'b0, rx_full = 1'b0, tx_empty = 1'b0, tx_req = 1'b0, smode = 1'b0;
  logic [3:0]  ssel_n = 4'hF;
  logic        stall, irq;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_irq_ctrl i_spi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_done_i(rx_done), .rx_full_i(rx_full),
    .tx_empty_i(tx_empty), .tx_shift_req_i(tx_req), .slave_mode_i(smode),
    .ssel_ni(ssel_n), .stall_o(stall), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // sets bits 2..5 by real events; ends with inputs idle
  task automatic make_all_sticky();
    @(negedge clk); smode = 1; rx_done = 1; rx_full = 1; tx_req = 1; tx_empty = 1; ssel_n = 4'hE;
    @(negedge clk); rx_done = 0; tx_req = 0; smode = 0; ssel_n = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R3 reset state
    rd(0, d); chk("R3 status", d, 0);
    rd(1, d); chk("R3 enable", d, 0);
    chk("R3 irq", {31'd0, irq}, 0);

    // R1/R2/R12 enable alias sweep
    for (int v = 0; v < 64; v++) begin
      logic [5:0] w, c, e;
      w = 6'((v * 7) & 63);
      c = 6'((v * 5 + 3) & 63);
      wr(2, 32'h3F);
      wr(1, 32'(v));
      rd(1, d); chk("R1 set", d, 32'(v));
      wr(1, {26'd0, w});
      e = 6'(v) | w;
      rd(2, d); chk("R1 zero keeps, readback at clear alias", d, {26'd0, e});
      wr(2, {26'd0, c});
      e = e & ~c;
      rd(1, d); chk("R2 clear", d, {26'd0, e});
      wr(1, 32'hFFFF_FFC0);
      rd(1, d); chk("R12 reserved write", d, {26'd0, e});
    end
    rd(3, d); chk("R12 unused addr", d, 0);
    rd_en = 0; addr = 1; #1; chk("R12 no read", rdata, 0);

    // R4 level flags
    wr(2, 32'h3F);
    for (int i = 0; i < 4; i++) begin
      rx_full = i[0]; tx_empty = i[1];
      #1; rd(0, d); chk("R4 level", d, 32'(i));
      wr(0, 32'h3);
      rd(0, d); chk("R4 write ignored", d, 32'(i));
    end
    rx_full = 0; tx_empty = 0;

    // R5/R6 overrun vs stall
    for (int i = 0; i < 8; i++) begin
      wr(0, 32'h3C);
      smode = i[0]; rx_done = i[1]; rx_full = i[2];
      #1; chk("R6 stall", {31'd0, stall}, {31'd0, ~i[0] & i[2]});
      step();
      rx_done = 0;
      rd(0, d); chk("R5 R6 overrun", {26'd0, d[5:2], 2'b0}, {29'd0, (i[0] & i[1] & i[2]), 2'b0});
    end
    smode = 0; rx_full = 0;

    // R7 underrun
    for (int i = 0; i < 8; i++) begin
      wr(0, 32'h3C);
      smode = i[0]; tx_req = i[1]; tx_empty = i[2];
      step();
      tx_req = 0;
      rd(0, d); chk("R7 underrun", {26'd0, d[5:2], 2'b0}, {28'd0, (i[0] & i[1] & i[2]), 3'b0});
    end
    smode = 0; tx_empty = 0;

    // R8/R9 select edge sweep (a = asserted pattern)
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        logic ea, ed;
        @(negedge clk); ssel_n = ~4'(p);
        step();
        wr(0, 32'h30);
        ssel_n = ~4'(q);
        step();
        ea = |(4'(q) & ~4'(p));
        ed = (p != 0) && (q == 0);
        rd(0, d); chk("R8 R9 select events", {30'd0, d[5:4]}, {30'd0, ed, ea});
      end
    end
    ssel_n = 4'hF; step();

    // R10 set beats clear; sticky; W1C
    wr(0, 32'h3C);
    @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h10; ssel_n = 4'hD;
    @(negedge clk); wr_en = 0; wdata = 0;
    rd(0, d); chk("R10 set beats clear", {31'd0, d[4]}, 1);
    repeat (3) step();
    rd(0, d); chk("R10 sticky", {31'd0, d[4]}, 1);
    wr(0, 32'h10);
    rd(0, d); chk("R10 w1c", {31'd0, d[4]}, 0);
    ssel_n = 4'hF; step();

    // R11 interrupt: every flag pattern against every mask
    for (int f = 0; f < 64; f++) begin
      make_all_sticky();
      wr(0, {26'd0, ~6'(f) & 6'h3C});
      rx_full = f[0]; tx_empty = f[1];
      for (int m = 0; m < 64; m++) begin
        logic prev;
        wr(2, 32'h3F);
        step();
        chk("R11 irq off", {31'd0, irq}, 0);
        @(negedge clk); wr_en = 1; addr = 1; wdata = 32'(m);
        @(negedge clk); wr_en = 0;
        prev = irq;
        step();
        chk("R11 irq level", {31'd0, irq}, {31'd0, |(6'(m) & 6'(f))});
        if (m == 63 && f == 63) chk("R11 registered lag", {31'd0, prev}, 0);
      end
      rx_full = 0; tx_empty = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule